// File: doc/BRIEF.md
# Three-Bank Register File with Memory Side-Effects

This block holds the architectural registers of a 60-bit word machine in three banks of eight. The data bank is 60 bits wide. The address bank and the index bank are 18 bits wide. Index slot 0 is wired to zero. One write port from the execute stage selects a bank and a slot. Two combinational read ports each select a bank and a slot and return a 60-bit value, zero-extended for the narrow banks.

Writing an address slot other than slot 0 also starts a memory transfer. Slots 1 to 5 load the word at the new address into the data slot with the same number. Slots 6 and 7 store the data slot with the same number to that address. Slot 0 only holds the value.

A transfer is checked against a configured memory limit before it starts. An address at or above the limit starts no transfer and halts the block. The halt lasts until reset. While a transfer is pending, `busy` is high and the write port is closed. The memory side uses a request that is held until a one-cycle done pulse.

Top module: `triple_bank_regs`

## Requirements
- R1: A synchronous active-low reset clears every register in all three banks to zero. It also drops `busy`, `mem_req` and `oob_halt`.
- R2: A data-bank write (bank code 0) stores all 60 bits. An address-bank write (code 1) or an index-bank write (code 2) keeps only bits 17:0, and the read ports return that value zero-extended to 60 bits. Both read ports see every register.
- R3: Index slot 0 always reads as zero, and writes to it leave it at zero.
- R4: An accepted write of value V (below the limit) to address slot k, where 1 ≤ k ≤ 5, raises `mem_req` with `mem_we`=0 and `mem_addr`=V from the next cycle. When `mem_done` arrives, `mem_rdata` goes into data slot k.
- R5: An accepted write of value V (below the limit) to address slot 6 or 7 raises `mem_req` with `mem_we`=1 and `mem_addr`=V from the next cycle. `mem_wdata` carries data slot 6 or 7 respectively, and that data slot is left unchanged.
- R6: A write to address slot 0 stores the value and starts no memory request and no halt, whatever the value.
- R7: `busy` and `mem_req` stay high, with a stable address, until the cycle of `mem_done`. While they are high, `wr_ready` is low and any write presented is dropped.
- R8: In the cycle where `mem_done` completes a load, a read port that selects the target data slot returns `mem_rdata` (write-first).
- R9: A write to address slot 1–7 whose value is at or above `MEM_LIMIT` stores the value but starts no request. It sets `oob_halt` from the next cycle, and the flag holds until reset. While halted, `wr_ready` is low and writes are dropped. The value `MEM_LIMIT`−1 is accepted as in bounds.
- R10: Bank code 3 is unused: writes to it change no register, and reads of it return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request from execute stage |
| wr_bank | input | 2 | Bank code: 0 data, 1 address, 2 index, 3 unused |
| wr_idx | input | 3 | Slot number |
| wr_data | input | 60 | Write value (narrow banks use bits 17:0) |
| wr_ready | output | 1 | Write port open (not busy, not halted) |
| rd_a_bank | input | 2 | Read port A bank code |
| rd_a_idx | input | 3 | Read port A slot |
| rd_a_data | output | 60 | Read port A value |
| rd_b_bank | input | 2 | Read port B bank code |
| rd_b_idx | input | 3 | Read port B slot |
| rd_b_data | output | 60 | Read port B value |
| mem_req | output | 1 | Memory request, held until done |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 18 | Word address |
| mem_wdata | output | 60 | Store data |
| mem_done | input | 1 | One-cycle completion pulse |
| mem_rdata | input | 60 | Load data, valid with `mem_done` |
| busy | output | 1 | Side-effect transfer pending |
| oob_halt | output | 1 | Out-of-bounds error, block halted |

## Verification
Two functions can fall in the same cycle: completion of a load into a data slot, and a read of that slot through a read port. The bench sets the behavioural memory to a few cycles of latency and keeps both read ports on the target slot. It samples the ports while the slot still holds its old value, and again in the exact cycle `mem_done` is high. It judges that the first sample shows the old value and the second already shows the loaded word on both ports.

// File: rtl/tbr_pkg.sv
// Shared types and constants for the three-bank register file.
// Assumes bank codes are fixed by the execute-stage encoding.
package tbr_pkg;
    typedef enum logic [1:0] {
        BK_DATA  = 2'd0,
        BK_ADDR  = 2'd1,
        BK_INDEX = 2'd2,
        BK_NONE  = 2'd3
    } bank_e;

    // Address slots at or above this number store; lower nonzero slots load.
    localparam int STORE_FROM = 6;
endpackage

// File: rtl/tbr_bank.sv
// One bank of DEPTH registers, WIDTH bits each, with a single write port.
// Assumes at most one write per cycle; HARD_ZERO0 wires slot 0 to zero.
module tbr_bank #(
    parameter int WIDTH      = 60,
    parameter int DEPTH      = 8,
    parameter int IW         = $clog2(DEPTH),
    parameter bit HARD_ZERO0 = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [IW-1:0]                widx,
    input  logic [WIDTH-1:0]             wdata,
    output logic [DEPTH-1:0][WIDTH-1:0]  q
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (HARD_ZERO0 && g == 0) begin : g_zero
            // Slot wired to zero; writes have nowhere to land.
            assign q[g] = '0;
        end else begin : g_reg
            // Holds one register, cleared by reset, loaded on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[g] <= '0;
                else if (we && widx == IW'(g))
                    q[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/tbr_sidefx.sv
// Starts and tracks the memory transfer caused by an address-slot write.
// Assumes writes are offered only when idle and not halted.
module tbr_sidefx
    import tbr_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DEPTH     = 8,
    parameter int IW        = $clog2(DEPTH),
    parameter int MEM_LIMIT = 131072
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_addr_wr,
    input  logic [IW-1:0]     acc_idx,
    input  logic [ADDR_W-1:0] acc_value,
    input  logic              mem_done,
    output logic              busy,
    output logic              is_store,
    output logic [IW-1:0]     pend_idx,
    output logic [ADDR_W-1:0] addr_q,
    output logic              halted,
    output logic              load_done
);
    localparam logic [ADDR_W:0] LIMIT_V = (ADDR_W + 1)'(MEM_LIMIT);

    logic has_effect;
    logic out_of_range;

    // Classifies the accepted write: does it have a side effect, and is it in range.
    always_comb begin
        has_effect   = acc_addr_wr && (acc_idx != '0);
        out_of_range = ({1'b0, acc_value} >= LIMIT_V);
    end

    // A load finishes on the done pulse of a non-store transfer.
    assign load_done = busy && mem_done && !is_store;

    // Transfer state: start on a side-effect write, finish on done, latch halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            is_store <= 1'b0;
            pend_idx <= '0;
            addr_q   <= '0;
            halted   <= 1'b0;
        end else if (busy) begin
            if (mem_done)
                busy <= 1'b0;
        end else if (has_effect) begin
            if (out_of_range) begin
                halted <= 1'b1;
            end else begin
                busy     <= 1'b1;
                is_store <= (acc_idx >= IW'(STORE_FROM));
                pend_idx <= acc_idx;
                addr_q   <= acc_value;
            end
        end
    end
endmodule

// File: rtl/tbr_rdport.sv
// One combinational read port over the three banks, with load bypass.
// Assumes narrow banks are zero-extended and bank code 3 reads zero.
module tbr_rdport
    import tbr_pkg::*;
#(
    parameter int DATA_W = 60,
    parameter int ADDR_W = 18,
    parameter int DEPTH  = 8,
    parameter int IW     = $clog2(DEPTH)
) (
    input  logic [1:0]                    bank,
    input  logic [IW-1:0]                 idx,
    input  logic [DEPTH-1:0][DATA_W-1:0]  dq,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  aq,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  iq,
    input  logic                          byp_en,
    input  logic [IW-1:0]                 byp_idx,
    input  logic [DATA_W-1:0]             byp_val,
    output logic [DATA_W-1:0]             rdata
);
    // Selects the addressed register, preferring a load finishing this cycle.
    always_comb begin
        unique case (bank_e'(bank))
            BK_DATA:  rdata = (byp_en && byp_idx == idx) ? byp_val : dq[idx];
            BK_ADDR:  rdata = DATA_W'(aq[idx]);
            BK_INDEX: rdata = DATA_W'(iq[idx]);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/triple_bank_regs.sv
// Three-bank register file whose address-slot writes load or store memory.
// Assumes the memory holds mem_req until a single-cycle mem_done.
module triple_bank_regs
    import tbr_pkg::*;
#(
    parameter int DATA_W    = 60,
    parameter int ADDR_W    = 18,
    parameter int DEPTH     = 8,
    parameter int MEM_LIMIT = 131072
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_bank,
    input  logic [2:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic [1:0]        rd_a_bank,
    input  logic [2:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [1:0]        rd_b_bank,
    input  logic [2:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_done,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              oob_halt
);
    localparam int IW = $clog2(DEPTH);

    logic                          accept;
    logic                          load_done;
    logic                          is_store;
    logic [IW-1:0]                 pend_idx;
    logic [ADDR_W-1:0]             addr_q;
    logic                          d_we, a_we, i_we;
    logic [IW-1:0]                 d_widx;
    logic [DATA_W-1:0]             d_wval;
    logic [DEPTH-1:0][DATA_W-1:0]  dq;
    logic [DEPTH-1:0][ADDR_W-1:0]  aq;
    logic [DEPTH-1:0][ADDR_W-1:0]  iq;

    // Write port is open only when no transfer is pending and not halted.
    assign wr_ready = !busy && !oob_halt;
    assign accept   = wr_en && wr_ready;

    // Routes the execute write or a finishing load to the bank write ports.
    always_comb begin
        a_we   = accept && (bank_e'(wr_bank) == BK_ADDR);
        i_we   = accept && (bank_e'(wr_bank) == BK_INDEX);
        d_we   = (accept && (bank_e'(wr_bank) == BK_DATA)) || load_done;
        d_widx = load_done ? pend_idx : wr_idx[IW-1:0];
        d_wval = load_done ? mem_rdata : wr_data;
    end

    tbr_bank #(.WIDTH(DATA_W), .DEPTH(DEPTH), .IW(IW), .HARD_ZERO0(1'b0)) u_data (
        .clk(clk), .rst_n(rst_n), .we(d_we), .widx(d_widx), .wdata(d_wval), .q(dq)
    );

    tbr_bank #(.WIDTH(ADDR_W), .DEPTH(DEPTH), .IW(IW), .HARD_ZERO0(1'b0)) u_addr (
        .clk(clk), .rst_n(rst_n), .we(a_we), .widx(wr_idx[IW-1:0]),
        .wdata(wr_data[ADDR_W-1:0]), .q(aq)
    );

    tbr_bank #(.WIDTH(ADDR_W), .DEPTH(DEPTH), .IW(IW), .HARD_ZERO0(1'b1)) u_index (
        .clk(clk), .rst_n(rst_n), .we(i_we), .widx(wr_idx[IW-1:0]),
        .wdata(wr_data[ADDR_W-1:0]), .q(iq)
    );

    tbr_sidefx #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IW(IW), .MEM_LIMIT(MEM_LIMIT)) u_fx (
        .clk(clk), .rst_n(rst_n), .acc_addr_wr(a_we), .acc_idx(wr_idx[IW-1:0]),
        .acc_value(wr_data[ADDR_W-1:0]), .mem_done(mem_done), .busy(busy),
        .is_store(is_store), .pend_idx(pend_idx), .addr_q(addr_q),
        .halted(oob_halt), .load_done(load_done)
    );

    tbr_rdport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .IW(IW)) u_rd_a (
        .bank(rd_a_bank), .idx(rd_a_idx[IW-1:0]), .dq(dq), .aq(aq), .iq(iq),
        .byp_en(load_done), .byp_idx(pend_idx), .byp_val(mem_rdata), .rdata(rd_a_data)
    );

    tbr_rdport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .IW(IW)) u_rd_b (
        .bank(rd_b_bank), .idx(rd_b_idx[IW-1:0]), .dq(dq), .aq(aq), .iq(iq),
        .byp_en(load_done), .byp_idx(pend_idx), .byp_val(mem_rdata), .rdata(rd_b_data)
    );

    // Memory side: request follows the pending flag, store data read live.
    assign mem_req   = busy;
    assign mem_we    = is_store;
    assign mem_addr  = addr_q;
    assign mem_wdata = dq[pend_idx];
endmodule

// File: rtl/tbr_checker.sv
// Protocol and side-effect properties for triple_bank_regs, bound to it below.
// Assumes the execute-stage bank code 1 selects the address bank.
module tbr_checker #(
    parameter int DATA_W    = 60,
    parameter int ADDR_W    = 18,
    parameter int MEM_LIMIT = 131072
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_ready,
    input logic [1:0]        wr_bank,
    input logic [2:0]        wr_idx,
    input logic [ADDR_W-1:0] wr_low,
    input logic [1:0]        rd_a_bank,
    input logic [2:0]        rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_done,
    input logic              busy,
    input logic              oob_halt
);
    localparam logic [ADDR_W:0] LIMIT_V = (ADDR_W + 1)'(MEM_LIMIT);

    logic addr_wr;
    logic in_rng;
    assign addr_wr = wr_en && wr_ready && (wr_bank == 2'd1);
    assign in_rng  = ({1'b0, wr_low} < LIMIT_V);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_req && !oob_halt));

    p_index_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_bank == 2'd2 && rd_a_idx == 3'd0) |-> (rd_a_data == '0));

    p_load_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && wr_idx >= 3'd1 && wr_idx <= 3'd5 && in_rng)
        |=> (mem_req && !mem_we && mem_addr == $past(wr_low)));

    p_store_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && wr_idx >= 3'd6 && in_rng)
        |=> (mem_req && mem_we && mem_addr == $past(wr_low)));

    p_slot0_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && wr_idx == 3'd0) |=> (!mem_req && !oob_halt));

    p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_port_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_ready);

    p_oob_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && wr_idx != 3'd0 && !in_rng) |=> (oob_halt && !mem_req));

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oob_halt |=> oob_halt);
endmodule

bind triple_bank_regs tbr_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MEM_LIMIT(MEM_LIMIT)
) u_tbr_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ready(wr_ready),
    .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_low(wr_data[ADDR_W-1:0]),
    .rd_a_bank(rd_a_bank), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_done(mem_done), .busy(busy), .oob_halt(oob_halt)
);

// File: tb/test_triple_bank_regs.sv
module test_triple_bank_regs;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 60;
    localparam int AW         = 18;
    localparam int LIMIT      = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_bank = '0;
    logic [2:0]    wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready;
    logic [1:0]    rd_a_bank = '0, rd_b_bank = '0;
    logic [2:0]    rd_a_idx = '0, rd_b_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data;
    logic          mem_req, mem_we, busy, oob_halt;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_done;
    logic [DW-1:0] mem_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int lat      = 2;
    int cnt;
    logic [DW-1:0] mem [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    triple_bank_regs #(.MEM_LIMIT(LIMIT)) i_triple_bank_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_ready(wr_ready), .rd_a_bank(rd_a_bank), .rd_a_idx(rd_a_idx),
        .rd_a_data(rd_a_data), .rd_b_bank(rd_b_bank), .rd_b_idx(rd_b_idx),
        .rd_b_data(rd_b_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_done(mem_done), .mem_rdata(mem_rdata),
        .busy(busy), .oob_halt(oob_halt)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return 60'hA5C_3F01_2B7E_9D46 ^ (DW'(a) * 60'h0_0010_0003_0001);
    endfunction

    // Behavioural memory: answers a held request after lat cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= 0;
            mem_done  <= 1'b0;
            mem_rdata <= '0;
            for (int i = 0; i < 64; i++) mem[i] <= pat(i);
        end else begin
            mem_done <= 1'b0;
            if (mem_req && !mem_done) begin
                if (cnt >= lat) begin
                    cnt      <= 0;
                    mem_done <= 1'b1;
                    if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
                    else        mem_rdata <= mem[mem_addr[5:0]];
                end else begin
                    cnt <= cnt + 1;
                end
            end
        end
    end

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] b, input logic [2:0] i, input logic [DW-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = b; wr_idx = i; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] b, input logic [2:0] i,
                      output logic [DW-1:0] va, output logic [DW-1:0] vb);
        rd_a_bank = b; rd_a_idx = i; rd_b_bank = b; rd_b_idx = i;
        #1;
        va = rd_a_data; vb = rd_b_data;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 60 && busy; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [DW-1:0] va, vb;
        do_reset();
        for (int b = 0; b < 3; b++)
            for (int i = 0; i < 8; i++) begin
                rd(2'(b), 3'(i), va, vb);
                check("R1 reg clear", va, '0);
            end
        check("R1 busy", DW'(busy), '0);
        check("R1 mem_req", DW'(mem_req), '0);
        check("R1 halt", DW'(oob_halt), '0);
    endtask

    task automatic t_widths();
        logic [DW-1:0] va, vb;
        wr(2'd0, 3'd5, 60'hFED_CBA9_8765_4321);
        rd(2'd0, 3'd5, va, vb);
        check("R2 data port A", va, 60'hFED_CBA9_8765_4321);
        check("R2 data port B", vb, 60'hFED_CBA9_8765_4321);
        wr(2'd1, 3'd0, 60'hFFF_FFFF_FFF1_2345);
        rd(2'd1, 3'd0, va, vb);
        check("R2 addr narrow", va, 60'h1_2345 & 60'h3_FFFF);
        wr(2'd2, 3'd5, '1);
        rd(2'd2, 3'd5, va, vb);
        check("R2 index narrow", vb, 60'h3_FFFF);
    endtask

    task automatic t_index_zero();
        logic [DW-1:0] va, vb;
        wr(2'd2, 3'd0, 60'h2_ABCD);
        rd(2'd2, 3'd0, va, vb);
        check("R3 index slot0 A", va, '0);
        check("R3 index slot0 B", vb, '0);
    endtask

    task automatic t_slot0_quiet();
        logic [DW-1:0] va, vb;
        wr(2'd1, 3'd0, DW'(LIMIT + 5));
        check("R6 no request", DW'(mem_req), '0);
        check("R6 no halt", DW'(oob_halt), '0);
        rd(2'd1, 3'd0, va, vb);
        check("R6 value kept", va, DW'(LIMIT + 5));
    endtask

    task automatic t_load();
        logic [DW-1:0] va, vb;
        lat = 2;
        wr(2'd1, 3'd3, 60'd7);
        check("R4 req", DW'(mem_req), 1);
        check("R4 we", DW'(mem_we), 0);
        check("R4 addr", DW'(mem_addr), 60'd7);
        wait_idle();
        rd(2'd0, 3'd3, va, vb);
        check("R4 loaded", va, pat(7));
        rd(2'd1, 3'd3, va, vb);
        check("R4 addr reg", va, 60'd7);
    endtask

    task automatic t_store();
        logic [DW-1:0] va, vb;
        wr(2'd0, 3'd6, 60'h123_4567_89AB_CDEF);
        wr(2'd1, 3'd6, 60'd20);
        check("R5 req", DW'(mem_req), 1);
        check("R5 we", DW'(mem_we), 1);
        check("R5 addr", DW'(mem_addr), 60'd20);
        check("R5 wdata", mem_wdata, 60'h123_4567_89AB_CDEF);
        wait_idle();
        @(negedge clk);
        check("R5 memory written", mem[20], 60'h123_4567_89AB_CDEF);
        rd(2'd0, 3'd6, va, vb);
        check("R5 data slot kept", va, 60'h123_4567_89AB_CDEF);
        wr(2'd0, 3'd7, 60'h0AA_55AA_55AA_55AA);
        wr(2'd1, 3'd7, 60'd21);
        check("R5 slot7 wdata", mem_wdata, 60'h0AA_55AA_55AA_55AA);
        wait_idle();
    endtask

    task automatic t_busy_block();
        logic [DW-1:0] va, vb;
        wr(2'd0, 3'd4, 60'h111);
        wr(2'd2, 3'd3, 60'h222);
        lat = 6;
        wr(2'd1, 3'd1, 60'd5);
        check("R7 ready low", DW'(wr_ready), 0);
        wr(2'd0, 3'd4, 60'h999);
        wr(2'd2, 3'd3, 60'h888);
        check("R7 still busy", DW'(busy), 1);
        check("R7 addr stable", DW'(mem_addr), 60'd5);
        wait_idle();
        check("R7 ready back", DW'(wr_ready), 1);
        rd(2'd0, 3'd4, va, vb);
        check("R7 dropped data write", va, 60'h111);
        rd(2'd2, 3'd3, va, vb);
        check("R7 dropped index write", va, 60'h222);
        rd(2'd0, 3'd1, va, vb);
        check("R7 load landed", va, pat(5));
    endtask

    task automatic t_bypass();
        logic [DW-1:0] va, vb;
        wr(2'd0, 3'd2, 60'h0DE_AD00_BEEF_0001);
        lat = 3;
        wr(2'd1, 3'd2, 60'd9);
        rd(2'd0, 3'd2, va, vb);
        check("R8 old value before done", va, 60'h0DE_AD00_BEEF_0001);
        for (int k = 0; k < 20 && !mem_done; k++) @(negedge clk);
        rd(2'd0, 3'd2, va, vb);
        check("R8 bypass port A", va, pat(9));
        check("R8 bypass port B", vb, pat(9));
        wait_idle();
        lat = 2;
    endtask

    task automatic t_reserved();
        logic [DW-1:0] va, vb;
        wr(2'd3, 3'd4, '1);
        rd(2'd3, 3'd4, va, vb);
        check("R10 reads zero", va, '0);
        rd(2'd0, 3'd4, va, vb);
        check("R10 data unchanged", va, 60'h111);
        rd(2'd2, 3'd4, va, vb);
        check("R10 index unchanged", va, '0);
    endtask

    task automatic t_oob();
        logic [DW-1:0] va, vb;
        wr(2'd1, 3'd5, DW'(LIMIT - 1));
        check("R9 limit-1 in bounds", DW'(mem_req), 1);
        check("R9 limit-1 no halt", DW'(oob_halt), 0);
        wait_idle();
        wr(2'd1, 3'd4, DW'(LIMIT));
        check("R9 halt set", DW'(oob_halt), 1);
        check("R9 no request", DW'(mem_req), 0);
        check("R9 ready low", DW'(wr_ready), 0);
        rd(2'd1, 3'd4, va, vb);
        check("R9 addr value kept", va, DW'(LIMIT));
        wr(2'd0, 3'd0, 60'h777);
        rd(2'd0, 3'd0, va, vb);
        check("R9 write dropped while halted", va, '0);
        repeat (3) @(negedge clk);
        check("R9 halt sticky", DW'(oob_halt), 1);
        do_reset();
        check("R1 halt cleared by reset", DW'(oob_halt), 0);
        rd(2'd1, 3'd4, va, vb);
        check("R1 addr cleared by reset", va, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_widths();
        t_index_zero();
        t_slot0_quiet();
        t_load();
        t_store();
        t_busy_block();
        t_bypass();
        t_reserved();
        t_oob();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule